// File: doc/BRIEF.md
# Raw NAND Host Register Front End

This block sits between a processor's register bus and an 8-bit raw NAND flash pin interface. Software writes command, address and data bytes into a small queue. The block replays each queued byte as one NAND bus cycle. Each cycle drives the command-latch or address-latch strobe as the entry type requires. The write and read strobes are held low for a programmable number of clocks.

Reading a single byte takes two steps. A write of any value to a read-request register queues a bus read. When the byte has been captured, a ready flag is raised and software fetches the byte from a separate result register. The block also offers page bursts of 256 or 512 bytes. A page write consumes queued data bytes. A page read issues the read cycles on its own and streams each byte to a side output for an external transfer engine. Both bursts are counted by an internal byte counter.

The block keeps a status word and latched interrupt flags. The flags are combined with a mask into one interrupt line. A self-clearing reset command clears the transfer counter and pulses a clear line to the error-correction accumulators.

Top module: `nandc_host_regs`

## Requirements
- R1: After reset, with the ready/busy input high, the status register (offset 1) reads 0x0011 and the interrupt status (offset 2), interrupt mask (offset 3) and reset register (offset 9) read 0. The interrupt output is low. Chip enable, write strobe and read strobe are high, and the command and address latches are low.
- R2: A write to offset 4 queues a command and a write to offset 5 queues an address. These produce a NAND cycle with the command latch or the address latch high, respectively. A write to offset 6 queues a data byte, which produces a cycle with both latches low. In every such cycle the byte drives the data pins, and the write strobe stays low for wr_dly+1 clocks. wr_dly is bits [7:4] of the control register (offset 0).
- R3: A write of any value to offset 7 queues a read. The read strobe stays low for rd_dly+1 clocks, where rd_dly is bits [3:0] of offset 0. The byte on the data pins at the end of the strobe is returned in bits [7:0] of offset 8. Interrupt bit 3 (read ready) is set exactly rd_dly+4 clocks after the request write.
- R4: The write queue holds 4 entries and replays them in the order they were written. Status bit 1 reads 1 while the queue holds 4 entries, and status bit 4 reads 1 while it is empty.
- R5: A queue write made while status bit 1 is set is dropped and sets interrupt bit 1 (overflow).
- R6: Interrupt bit 2 is set when the queue goes from non-empty to empty. It is not set while entries are still waiting.
- R7: Writing 1 to a bit of offset 2 clears that interrupt bit. Bits written with 0 are left unchanged.
- R8: The interrupt output is high exactly when some bit is set in both the interrupt status and the mask (offset 3, bits [4:0]).
- R9: Status bit 0 follows the ready/busy input one clock late. A low-to-high change on that input sets interrupt bit 0.
- R10: Writing 1 to bit 0 of offset 9 makes that bit read 1, and the ECC clear output stay high, for one clock. Both then return to 0, and the page byte counter is restarted from zero.
- R11: Writing bit 1 of the page control register (offset 10) starts a page write and sets status bit 2. The page length is 512 bytes when bit 8 of offset 0 is 1 and 256 bytes when it is 0. After that many queued data bytes have completed on the bus, status bit 2 clears and interrupt bit 4 is set.
- R12: Writing bit 0 of offset 10 starts a page read and sets status bit 3. The block issues one read cycle per page byte and presents each captured byte on the page byte output with a one-clock valid pulse. Status bit 3 clears after the last byte.
- R13: A write to offset 10 while a page read or a page write is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr (combinational) |
| irq_o | output | 1 | Masked interrupt |
| ecc_clr_o | output | 1 | One-clock clear for the error-correction accumulators |
| pg_byte_o | output | 8 | Byte captured by a page read |
| pg_byte_vld_o | output | 1 | pg_byte_o is valid this clock |
| nand_ce_n | output | 1 | Chip enable, low while a bus cycle runs |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe |
| nand_re_n | output | 1 | Read strobe |
| nand_dq_o | output | 8 | Data pins, outgoing |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 8 | Data pins, incoming |
| nand_rb | input | 1 | Ready/busy from the device, high when ready |

## Verification
A queued entry reaches the pins one clock after its register write: a setup clock, then the strobe for delay+1 clocks, then a hold clock. The read-ready flag therefore lands rd_dly+4 clock edges after the request write. The bench reads the interrupt register after rd_dly+3 edges and again after rd_dly+4 edges, and expects the flag clear and then set. Strobe widths are measured by a pin monitor that samples on the falling clock edge, so they are checked without needing the exact start cycle. The reset register and ready/busy flags are read at the first falling edge after their cause, when they are due. Queue and page results are read only after the bus has gone idle.

// File: rtl/nandc_pkg.sv
package nandc_pkg;

    localparam int BUS_W = 16;
    localparam int IRQ_W = 5;
    localparam int ST_W  = 5;

    // register offsets
    localparam logic [3:0] OFF_CTRL   = 4'd0;
    localparam logic [3:0] OFF_STAT   = 4'd1;
    localparam logic [3:0] OFF_ISTAT  = 4'd2;
    localparam logic [3:0] OFF_IMASK  = 4'd3;
    localparam logic [3:0] OFF_CMD    = 4'd4;
    localparam logic [3:0] OFF_ADDR   = 4'd5;
    localparam logic [3:0] OFF_DWR    = 4'd6;
    localparam logic [3:0] OFF_RDREQ  = 4'd7;
    localparam logic [3:0] OFF_RDDATA = 4'd8;
    localparam logic [3:0] OFF_RSTC   = 4'd9;
    localparam logic [3:0] OFF_PGCTL  = 4'd10;

    // interrupt flag positions
    localparam int IRQ_NB    = 0;
    localparam int IRQ_OVF   = 1;
    localparam int IRQ_EDGE  = 2;
    localparam int IRQ_RRDY  = 3;
    localparam int IRQ_WDONE = 4;

    typedef enum logic [1:0] {
        ENT_CMD  = 2'd0,
        ENT_ADDR = 2'd1,
        ENT_DATA = 2'd2,
        ENT_RREQ = 2'd3
    } ent_kind_e;

    typedef struct packed {
        ent_kind_e  kind;
        logic [7:0] dat;
    } wb_ent_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_STRB  = 2'd2,
        SQ_HOLD  = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic empty;
        logic pg_rd;
        logic pg_wr;
        logic full;
        logic rb;
    } status_t;

    function automatic logic is_queue_off(input logic [3:0] off);
        return (off == OFF_CMD) || (off == OFF_ADDR) ||
               (off == OFF_DWR) || (off == OFF_RDREQ);
    endfunction

    function automatic ent_kind_e off_to_kind(input logic [3:0] off);
        ent_kind_e k;
        case (off)
            OFF_CMD:  k = ENT_CMD;
            OFF_ADDR: k = ENT_ADDR;
            OFF_DWR:  k = ENT_DATA;
            default:  k = ENT_RREQ;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/nandc_wbuf.sv
module nandc_wbuf
    import nandc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  wb_ent_t push_ent,
    input  logic    pop,
    output wb_ent_t head,
    output logic    full,
    output logic    empty,
    output logic    drained
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    wb_ent_t            mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   cnt;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head    = mem[rd_ptr];
    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign drained = pop && !push && (cnt == CNT_W'(1));

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);  // R4
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);  // R5

endmodule

// File: rtl/nandc_seq.sv
module nandc_seq
    import nandc_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  wb_ent_t          start_ent,
    input  logic             start_page,
    input  logic [DLY_W-1:0] rd_dly,
    input  logic [DLY_W-1:0] wr_dly,
    output logic             busy,
    output logic             done,
    output ent_kind_e        done_kind,
    output logic             done_page,
    output logic [7:0]       cap_data,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_o,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_i
);
    seq_st_e          st;
    wb_ent_t          cur;
    logic             cur_pg;
    logic [DLY_W-1:0] cnt;
    logic [7:0]       cap;
    logic             is_rd, active;

    assign is_rd  = (cur.kind == ENT_RREQ);
    assign active = (st != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            cur    <= '{kind: ENT_CMD, dat: 8'h00};
            cur_pg <= 1'b0;
            cnt    <= '0;
            cap    <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (start) begin
                    cur    <= start_ent;
                    cur_pg <= start_page;
                    st     <= SQ_SETUP;
                end
                SQ_SETUP: begin
                    cnt <= is_rd ? rd_dly : wr_dly;
                    st  <= SQ_STRB;
                end
                SQ_STRB: begin
                    if (cnt == '0) begin
                        st <= SQ_HOLD;
                        if (is_rd) cap <= nand_dq_i;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy       = active;
    assign done       = (st == SQ_HOLD);
    assign done_kind  = cur.kind;
    assign done_page  = cur_pg;
    assign cap_data   = cap;

    assign nand_ce_n  = !active;
    assign nand_cle   = active && (cur.kind == ENT_CMD);
    assign nand_ale   = active && (cur.kind == ENT_ADDR);
    assign nand_we_n  = !((st == SQ_STRB) && !is_rd);
    assign nand_re_n  = !((st == SQ_STRB) && is_rd);
    assign nand_dq_o  = cur.dat;
    assign nand_dq_oe = active && !is_rd;

    AST_WE_DQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_dq_o) && $stable(nand_cle) && $stable(nand_ale)));  // R2
    AST_RE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> (!nand_dq_oe && nand_we_n));  // R3

endmodule

// File: rtl/nandc_host_regs.sv
module nandc_host_regs
    import nandc_pkg::*;
#(
    parameter int WB_DEPTH   = 4,
    parameter int DLY_W      = 4,
    parameter int PAGE_SMALL = 256,
    parameter int PAGE_LARGE = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [3:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq_o,
    output logic             ecc_clr_o,
    output logic [7:0]       pg_byte_o,
    output logic             pg_byte_vld_o,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_o,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_i,
    input  logic             nand_rb
);
    localparam int CNT_W  = $clog2(PAGE_LARGE);
    localparam int CTRL_W = 2 * DLY_W + 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic [IRQ_W-1:0]  irq_q, mask_q, irq_set, w1c;
    logic [7:0]        rd_q;
    logic              rst_busy, rb_q, rb_d;
    logic              pg_wr_pend, pg_rd_pend;
    logic [CNT_W-1:0]  pg_cnt, pg_len_m1;
    logic              pg_evt, pg_last, rd_done;
    logic [DLY_W-1:0]  rd_dly, wr_dly;
    logic              big_page;
    status_t           status;

    logic              q_wr, wb_push, wb_ovf, wb_pop, wb_full, wb_empty, wb_drained;
    wb_ent_t           push_ent, wb_head, start_ent;
    logic              seq_start, seq_busy, seq_done, seq_done_page;
    ent_kind_e         seq_done_kind;
    logic [7:0]        seq_cap;
    logic              unused_bits;

    assign unused_bits = ^bus_wdata[BUS_W-1:CTRL_W];

    assign rd_dly   = ctrl_q[DLY_W-1:0];
    assign wr_dly   = ctrl_q[2*DLY_W-1:DLY_W];
    assign big_page = ctrl_q[2*DLY_W];

    // register-write decode into the queue
    assign q_wr          = bus_we && is_queue_off(bus_addr);
    assign wb_push       = q_wr && !wb_full;
    assign wb_ovf        = q_wr && wb_full;
    assign push_ent.kind = off_to_kind(bus_addr);
    assign push_ent.dat  = bus_wdata[7:0];

    // queued entries first, then autonomous page-read cycles
    assign seq_start = !seq_busy && (!wb_empty || pg_rd_pend);
    assign wb_pop    = seq_start && !wb_empty;

    always_comb begin
        if (wb_empty) begin
            start_ent.kind = ENT_RREQ;
            start_ent.dat  = 8'h00;
        end else begin
            start_ent = wb_head;
        end
    end

    nandc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk      (clk),
        .rst      (rst),
        .push     (wb_push),
        .push_ent (push_ent),
        .pop      (wb_pop),
        .head     (wb_head),
        .full     (wb_full),
        .empty    (wb_empty),
        .drained  (wb_drained)
    );

    nandc_seq #(.DLY_W(DLY_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (seq_start),
        .start_ent  (start_ent),
        .start_page (wb_empty),
        .rd_dly     (rd_dly),
        .wr_dly     (wr_dly),
        .busy       (seq_busy),
        .done       (seq_done),
        .done_kind  (seq_done_kind),
        .done_page  (seq_done_page),
        .cap_data   (seq_cap),
        .nand_ce_n  (nand_ce_n),
        .nand_cle   (nand_cle),
        .nand_ale   (nand_ale),
        .nand_we_n  (nand_we_n),
        .nand_re_n  (nand_re_n),
        .nand_dq_o  (nand_dq_o),
        .nand_dq_oe (nand_dq_oe),
        .nand_dq_i  (nand_dq_i)
    );

    // completion bookkeeping
    assign rd_done   = seq_done && (seq_done_kind == ENT_RREQ) && !seq_done_page;
    assign pg_len_m1 = big_page ? CNT_W'(PAGE_LARGE - 1) : CNT_W'(PAGE_SMALL - 1);
    assign pg_evt    = seq_done && (seq_done_page || ((seq_done_kind == ENT_DATA) && pg_wr_pend));
    assign pg_last   = pg_evt && !rst_busy && (pg_cnt == pg_len_m1);

    always_comb begin
        irq_set            = '0;
        irq_set[IRQ_NB]    = rb_q && !rb_d;
        irq_set[IRQ_OVF]   = wb_ovf;
        irq_set[IRQ_EDGE]  = wb_drained;
        irq_set[IRQ_RRDY]  = rd_done;
        irq_set[IRQ_WDONE] = pg_last && pg_wr_pend;
        w1c = (bus_we && bus_addr == OFF_ISTAT) ? bus_wdata[IRQ_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            mask_q     <= '0;
            irq_q      <= '0;
            rd_q       <= '0;
            rst_busy   <= 1'b0;
            rb_q       <= 1'b1;
            rb_d       <= 1'b1;
            pg_wr_pend <= 1'b0;
            pg_rd_pend <= 1'b0;
            pg_cnt     <= '0;
        end else begin
            rb_q     <= nand_rb;
            rb_d     <= rb_q;
            irq_q    <= (irq_q & ~w1c) | irq_set;
            rst_busy <= bus_we && (bus_addr == OFF_RSTC) && bus_wdata[0];
            if (bus_we && bus_addr == OFF_CTRL)  ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (bus_we && bus_addr == OFF_IMASK) mask_q <= bus_wdata[IRQ_W-1:0];
            if (rd_done) rd_q <= seq_cap;

            if (rst_busy)    pg_cnt <= '0;
            else if (pg_evt) pg_cnt <= pg_last ? '0 : pg_cnt + 1'b1;

            if (pg_last) begin
                pg_wr_pend <= 1'b0;
                pg_rd_pend <= 1'b0;
            end else if (bus_we && bus_addr == OFF_PGCTL && !pg_wr_pend && !pg_rd_pend) begin
                if (bus_wdata[0])      pg_rd_pend <= 1'b1;
                else if (bus_wdata[1]) pg_wr_pend <= 1'b1;
            end
        end
    end

    assign status = '{empty: wb_empty, pg_rd: pg_rd_pend, pg_wr: pg_wr_pend,
                      full: wb_full, rb: rb_q};

    always_comb begin
        case (bus_addr)
            OFF_CTRL:   bus_rdata = BUS_W'(ctrl_q);
            OFF_STAT:   bus_rdata = BUS_W'(status);
            OFF_ISTAT:  bus_rdata = BUS_W'(irq_q);
            OFF_IMASK:  bus_rdata = BUS_W'(mask_q);
            OFF_RDDATA: bus_rdata = BUS_W'(rd_q);
            OFF_RSTC:   bus_rdata = BUS_W'(rst_busy);
            OFF_PGCTL:  bus_rdata = BUS_W'({pg_wr_pend, pg_rd_pend});
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_o         = |(irq_q & mask_q);
    assign ecc_clr_o     = rst_busy;
    assign pg_byte_o     = seq_cap;
    assign pg_byte_vld_o = seq_done && seq_done_page;

    AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
        (q_wr && wb_full) |=> irq_q[IRQ_OVF]);  // R5
    AST_EDGE_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_empty) |-> irq_q[IRQ_EDGE]);  // R6
    AST_RRDY_FLAG: assert property (@(posedge clk) disable iff (rst)
        (seq_done && seq_done_kind == ENT_RREQ && !seq_done_page) |=> irq_q[IRQ_RRDY]);  // R3
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        rst_busy |=> (pg_cnt == '0));  // R10
    AST_PG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pg_wr_pend && pg_rd_pend));  // R13

endmodule

// File: tb/nandc_host_regs_test.sv
module nandc_host_regs_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        irq_o, ecc_clr_o, pg_byte_vld_o;
    logic [7:0]  pg_byte_o;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o, nand_dq_i;
    logic        nand_rb;

    always #5 clk = ~clk;

    nandc_host_regs uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .ecc_clr_o(ecc_clr_o), .pg_byte_o(pg_byte_o), .pg_byte_vld_o(pg_byte_vld_o),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // pin monitor
    logic [1:0] lk [1024];
    logic [7:0] ld [1024];
    int         lw [1024];
    int log_n = 0, we_run = 0, re_run = 0, re_last_w = 0, rd_n = 0;
    int pg_seen = 0, pg_bad = 0;

    function automatic logic [7:0] rd_pat(input int n);
        return 8'(n * 37 + 5);
    endfunction

    assign nand_dq_i = rd_pat(rd_n);

    always @(negedge clk) begin
        if (pg_byte_vld_o) begin
            pg_seen++;
            if (pg_byte_o !== rd_pat(rd_n)) pg_bad++;
        end
        if (!nand_we_n) we_run++;
        else if (we_run > 0) begin
            if (log_n < 1024) begin
                lk[log_n] = nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd0);
                ld[log_n] = nand_dq_o;
                lw[log_n] = we_run;
            end
            log_n++;
            we_run = 0;
        end
        if (!nand_re_n) re_run++;
        else if (re_run > 0) begin
            re_last_w = re_run;
            re_run = 0;
            rd_n++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(4'd1, s);
            if (s[4] && !s[3] && nand_ce_n) break;
        end
    endtask

    task automatic push_data(input int n, input int base);
        logic [15:0] s;
        for (int i = 0; i < n; i++) begin
            rd(4'd1, s);
            while (s[1]) rd(4'd1, s);
            wr(4'd6, 16'((base + i) & 8'hFF));
        end
        wait_idle();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] v;
        int exp;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; nand_rb = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(4'd1, v); chk("R1", "status", v, 16'h0011);
        rd(4'd2, v); chk("R1", "irq status", v, 0);
        rd(4'd3, v); chk("R1", "mask", v, 0);
        rd(4'd9, v); chk("R1", "reset reg", v, 0);
        chk("R1", "irq_o", irq_o, 0);
        chk("R1", "pins", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);

        // R2 / R3 / R7 sweep over strobe delays
        for (int d = 0; d < 8; d++) begin
            int rdly;
            rdly = 7 - d;
            wr(4'd0, 16'((d << 4) | rdly));
            log_n = 0;
            wr(4'd4, 16'(8'h30 + d));
            wr(4'd5, 16'(8'h40 + d));
            wr(4'd6, 16'(8'h50 + d));
            wait_idle();
            chk("R2", "cycle count", log_n, 3);
            chk("R2", "cmd latch", lk[0], 1);
            chk("R2", "addr latch", lk[1], 2);
            chk("R2", "data latch", lk[2], 0);
            chk("R2", "cmd byte", ld[0], 8'h30 + d);
            chk("R2", "addr byte", ld[1], 8'h40 + d);
            chk("R2", "data byte", ld[2], 8'h50 + d);
            for (int k = 0; k < 3; k++) chk("R2", "we width", lw[k], d + 1);

            wr(4'd2, 16'h001F);
            exp = rd_pat(rd_n);
            wr(4'd7, 16'hBEEF);
            repeat (rdly + 3) @(posedge clk);
            rd(4'd2, v); chk("R3", "flags before ready", v, 16'h0004);
            rd(4'd2, v); chk("R3", "flags at ready", v, 16'h000C);
            rd(4'd8, v); chk("R3", "read byte", v, exp);
            chk("R3", "re width", re_last_w, rdly + 1);
            wr(4'd2, 16'h0008);
            rd(4'd2, v); chk("R7", "w1c keeps other bits", v, 16'h0004);
        end

        // R4 / R5 / R6 queue depth, order, overflow, drain edge
        wr(4'd0, 16'h00F0);
        wr(4'd2, 16'h001F);
        log_n = 0;
        for (int i = 0; i < 5; i++) wr(4'd6, 16'(8'hA0 + i));
        rd(4'd1, v); chk("R4", "full bit", v[1], 1);
        chk("R4", "empty bit", v[4], 0);
        rd(4'd2, v); chk("R6", "no edge while queued", v, 0);
        wr(4'd6, 16'h00A5);
        rd(4'd2, v); chk("R5", "overflow flag", v, 16'h0002);
        wait_idle();
        chk("R5", "dropped entry", log_n, 5);
        for (int i = 0; i < 5; i++) chk("R4", "replay order", ld[i], 8'hA0 + i);
        rd(4'd1, v); chk("R4", "status after drain", v, 16'h0011);
        rd(4'd2, v); chk("R6", "edge flag", v, 16'h0006);

        // R8 mask
        wr(4'd2, 16'h0002);
        wr(4'd3, 16'h0002);
        @(negedge clk); chk("R8", "irq_o masked off", irq_o, 0);
        wr(4'd3, 16'h0004);
        @(negedge clk); chk("R8", "irq_o enabled", irq_o, 1);
        rd(4'd3, v); chk("R8", "mask readback", v, 16'h0004);
        wr(4'd2, 16'h0004);
        @(negedge clk); chk("R8", "irq_o after clear", irq_o, 0);
        wr(4'd3, 16'h0000);

        // R9 ready/busy
        wr(4'd2, 16'h001F);
        @(negedge clk) nand_rb = 1'b0;
        rd(4'd1, v); chk("R9", "status rb low", v[0], 0);
        rd(4'd2, v); chk("R9", "no event on fall", v[0], 0);
        @(negedge clk) nand_rb = 1'b1;
        rd(4'd1, v); chk("R9", "status rb high", v[0], 1);
        rd(4'd2, v); chk("R9", "not-busy event", v[0], 1);

        // R10 self-clearing reset
        wr(4'd9, 16'h0001);
        rd(4'd9, v); chk("R10", "reset bit busy", v, 1);
        chk("R10", "ecc clear high", ecc_clr_o, 1);
        rd(4'd9, v); chk("R10", "reset bit cleared", v, 0);
        chk("R10", "ecc clear low", ecc_clr_o, 0);

        // R11 / R13 page write, 256 bytes
        wr(4'd0, 16'h0000);
        wr(4'd2, 16'h001F);
        wr(4'd10, 16'h0002);
        rd(4'd1, v); chk("R11", "page write pending", v[2], 1);
        wr(4'd10, 16'h0001);
        rd(4'd1, v); chk("R13", "read start ignored", v[3:2], 2'b01);
        push_data(255, 0);
        rd(4'd1, v); chk("R11", "pending at len-1", v[2], 1);
        rd(4'd2, v); chk("R11", "no done at len-1", v[4], 0);
        push_data(1, 0);
        rd(4'd1, v); chk("R11", "pending cleared 256", v[2], 0);
        rd(4'd2, v); chk("R11", "done flag 256", v[4], 1);

        // R11 page write, 512 bytes
        wr(4'd0, 16'h0100);
        wr(4'd2, 16'h001F);
        wr(4'd10, 16'h0002);
        push_data(511, 7);
        rd(4'd1, v); chk("R11", "pending at 511", v[2], 1);
        push_data(1, 7);
        rd(4'd1, v); chk("R11", "pending cleared 512", v[2], 0);
        rd(4'd2, v); chk("R11", "done flag 512", v[4], 1);

        // R10 counter restart
        wr(4'd0, 16'h0000);
        wr(4'd2, 16'h001F);
        wr(4'd10, 16'h0002);
        push_data(10, 3);
        wr(4'd9, 16'h0001);
        push_data(255, 3);
        rd(4'd1, v); chk("R10", "counter restarted", v[2], 1);
        push_data(1, 3);
        rd(4'd1, v); chk("R10", "page done after restart", v[2], 0);

        // R12 page read, 256 then 512 bytes
        for (int p = 0; p < 2; p++) begin
            wr(4'd0, p ? 16'h0111 : 16'h0000);
            pg_seen = 0; pg_bad = 0;
            wr(4'd10, 16'h0001);
            rd(4'd1, v); chk("R12", "page read pending", v[3], 1);
            for (int i = 0; i < 20000; i++) begin
                rd(4'd1, v);
                if (!v[3]) break;
            end
            wait_idle();
            chk("R12", "bytes streamed", pg_seen, p ? 512 : 256);
            chk("R12", "byte values", pg_bad, 0);
            rd(4'd1, v); chk("R12", "pending cleared", v[3], 0);
        end

        summary();
    end

endmodule